// File: doc/BRIEF.md
# Zero-Crossing Event Counter with Multicast Notification

This block keeps one signed synchronization count and changes it only by atomic addition. Two sources can add to it: ordinary stores, which carry a signed amount, and returning acknowledgments, which carry a transfer size. Both are applied in the same cycle, so software never needs a read-modify-write sequence. A typical use is a credit pool. A producer subtracts a fixed amount, for example 20 bytes, for each item it hands out. Each acknowledgment that comes back adds the same amount. When every item has been acknowledged, the count is zero again.

Software uses the configuration port to set up four things: a table of up to four destination addresses, a per-slot enable mask, one notification word, and the starting value of the count. When an addition takes the count from a non-zero value to zero, the block starts a notification round. The round sends one outgoing packet to each enabled slot. Each packet carries the slot's address and the notification word. Packets go out in ascending slot order under valid/ready flow control. Additions keep working while a round is in progress, and further zero crossings are queued as pending rounds.

A two-state sequencer drives the output. In `ST_IDLE` the sequencer waits for a pending round. The *round start* transition moves it to `ST_SEND`. The *empty round* transition stays in `ST_IDLE` and drops the round when the mask is zero. In `ST_SEND`, the *advance* transition moves to the next enabled slot after each accepted packet. The *round end* transition returns to `ST_IDLE` after the last enabled slot is accepted.

Top module: `evt_zero_notifier`

## Requirements
- R1: After reset, `count_value` is 0, `pkt_valid` is low and the enable mask is all zero. A zero crossing before any mask is written therefore produces no packet.
- R2: A cycle with `st_valid` high adds `st_value` to the count as a CNT_W-bit two's-complement sum that wraps on overflow. With no add and no initialisation, the count holds.
- R3: A cycle with `ack_valid` high adds `ack_size` the same way. A store and an acknowledgment in the same cycle add their sum. An acknowledgment never causes any packet except through a zero crossing.
- R4: A configuration write with `cfg_op` = 3 loads `cfg_data` into the count. This load takes priority over any store or acknowledgment in the same cycle, which are then discarded. A load never starts a round, even a load of zero.
- R5: A round is started only by a cycle in which an add takes the count from a non-zero value to zero. An add that leaves a zero count at zero starts nothing.
- R6: `cfg_op` = 0 writes `cfg_data` into the address of slot `cfg_slot`, and `cfg_op` = 1 writes the notification word. Each packet carries the address of its slot in `pkt_addr`, the slot index in `pkt_slot`, and in `pkt_data` the word as it was when its round started.
- R7: `cfg_op` = 2 writes the enable mask, where bit i enables slot i. A round sends exactly one packet per enabled slot, in ascending slot index, and skips disabled slots. A round that starts with an empty mask sends nothing.
- R8: While `pkt_valid` is high and `pkt_ready` is low, the valid signal and all packet fields stay unchanged. Each cycle with both high transfers exactly one packet.
- R9: Additions during a round are applied normally. Each further zero crossing is queued (up to 2^PEND_W-1 outstanding) and gives its own complete round later.
- R10: Used as a credit pool, repeated stores of -20 from a zero count start nothing. The acknowledgments of +20 that bring the count back to zero start exactly one round.
- R11: When the sequencer is idle, `pkt_valid` is still low in the first cycle that `count_value` shows the zero. It rises in the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_op | input | 2 | 0 slot address, 1 word, 2 enable mask, 3 load count |
| cfg_slot | input | SLOT_W | Slot index for address writes |
| cfg_data | input | CFG_W | Configuration write value |
| st_valid | input | 1 | Store strobe |
| st_value | input | CNT_W | Signed amount added by a store |
| ack_valid | input | 1 | Acknowledgment strobe |
| ack_size | input | CNT_W | Signed amount added by an acknowledgment |
| pkt_valid | output | 1 | Notification packet valid |
| pkt_ready | input | 1 | Downstream accepts the packet |
| pkt_addr | output | ADDR_W | Destination address of the packet |
| pkt_data | output | WORD_W | Notification word |
| pkt_slot | output | SLOT_W | Slot index of the packet |
| count_value | output | CNT_W | Current count |

## Verification
The assertions rely on two conditions at the inputs. The mask, addresses and word must not be rewritten in the cycle a round starts. The downstream side may hold `pkt_ready` low for any length of time, but the sequencer must keep its packet stable during such a stall. The stimulus changes configuration only while the block is idle. It drives `pkt_ready` from fixed patterns (always high, alternating, one cycle in three, held low) so that stalls stay legal. The bench sweeps all sixteen enable masks and checks every packet against an order and content computed arithmetically.

// File: rtl/ezn_pkg.sv
package ezn_pkg;

    typedef enum logic [1:0] {
        CFG_ADDR = 2'd0,
        CFG_WORD = 2'd1,
        CFG_MASK = 2'd2,
        CFG_LOAD = 2'd3
    } cfg_op_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } seq_state_e;

endpackage

// File: rtl/ezn_accum.sv
module ezn_accum #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic [CNT_W-1:0] load_val,
    input  logic             st_valid,
    input  logic [CNT_W-1:0] st_value,
    input  logic             ack_valid,
    input  logic [CNT_W-1:0] ack_size,
    output logic [CNT_W-1:0] count_q,
    output logic             zero_hit
);

    logic [CNT_W-1:0] st_term;
    logic [CNT_W-1:0] ack_term;
    logic [CNT_W-1:0] sum;
    logic             any_add;

    always_comb begin
        st_term  = st_valid  ? st_value : '0;
        ack_term = ack_valid ? ack_size : '0;
        any_add  = st_valid | ack_valid;
        sum      = count_q + st_term + ack_term;
        zero_hit = !load_en && any_add && (sum == '0) && (count_q != '0);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_en) begin
            count_q <= load_val;
        end else if (any_add) begin
            count_q <= sum;
        end
    end

    // R5: a reported crossing leaves the count at zero
    a_r5_hit_leaves_zero: assert property (@(posedge clk) disable iff (!rst_n)
        zero_hit |=> (count_q == '0));

    // R4: a load wins over any add in the same cycle
    a_r4_load_wins: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (count_q == $past(load_val)));

    // R2: with no add and no load the count holds
    a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_en && !st_valid && !ack_valid) |=> $stable(count_q));

endmodule

// File: rtl/ezn_cfg_regs.sv
module ezn_cfg_regs
    import ezn_pkg::*;
#(
    parameter int N_SLOT = 4,
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int CFG_W  = 32,
    parameter int SLOT_W = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           cfg_valid,
    input  logic [1:0]                     cfg_op,
    input  logic [SLOT_W-1:0]              cfg_slot,
    input  logic [CFG_W-1:0]               cfg_data,
    output logic [N_SLOT-1:0][ADDR_W-1:0]  addr_tbl,
    output logic [WORD_W-1:0]              word_q,
    output logic [N_SLOT-1:0]              mask_q
);

    logic wr_addr;
    logic wr_word;
    logic wr_mask;

    always_comb begin
        wr_addr = 1'b0;
        wr_word = 1'b0;
        wr_mask = 1'b0;
        unique case (cfg_op_e'(cfg_op))
            CFG_ADDR: wr_addr = cfg_valid;
            CFG_WORD: wr_word = cfg_valid;
            CFG_MASK: wr_mask = cfg_valid;
            CFG_LOAD: ;
        endcase
    end

    for (genvar s = 0; s < N_SLOT; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                addr_tbl[s] <= '0;
            end else if (wr_addr && (cfg_slot == SLOT_W'(s))) begin
                addr_tbl[s] <= ADDR_W'(cfg_data);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
            mask_q <= '0;
        end else begin
            if (wr_word) word_q <= WORD_W'(cfg_data);
            if (wr_mask) mask_q <= N_SLOT'(cfg_data);
        end
    end

endmodule

// File: rtl/ezn_notify_seq.sv
module ezn_notify_seq
    import ezn_pkg::*;
#(
    parameter int N_SLOT = 4,
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int PEND_W = 3,
    parameter int SLOT_W = 2
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           zero_hit,
    input  logic [N_SLOT-1:0]              mask,
    input  logic [WORD_W-1:0]              word,
    input  logic [N_SLOT-1:0][ADDR_W-1:0]  addr_tbl,
    input  logic                           pkt_ready,
    output logic                           pkt_valid,
    output logic [ADDR_W-1:0]              pkt_addr,
    output logic [WORD_W-1:0]              pkt_data,
    output logic [SLOT_W-1:0]              pkt_slot
);

    localparam logic [PEND_W-1:0] PEND_MAX = '1;

    seq_state_e        state_q;
    seq_state_e        state_d;
    logic [PEND_W-1:0] pend_q;
    logic [N_SLOT-1:0] rem_q;
    logic [N_SLOT-1:0] snap_q;
    logic [WORD_W-1:0] word_snap_q;
    logic [SLOT_W-1:0] cur_slot;
    logic [N_SLOT-1:0] cur_bit;
    logic [N_SLOT-1:0] rem_after;
    logic              round_take;
    logic              fire;
    logic              pend_inc;

    // lowest remaining enabled slot
    always_comb begin
        cur_slot = '0;
        for (int i = N_SLOT - 1; i >= 0; i--) begin
            if (rem_q[i]) cur_slot = SLOT_W'(i);
        end
        cur_bit   = N_SLOT'(1) << cur_slot;
        rem_after = rem_q & ~cur_bit;
    end

    always_comb begin
        round_take = (state_q == ST_IDLE) && (pend_q != '0);
        fire       = (state_q == ST_SEND) && pkt_ready;
        pend_inc   = zero_hit && ((pend_q != PEND_MAX) || round_take);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (round_take && (mask != '0)) state_d = ST_SEND;
            ST_SEND: if (fire && (rem_after == '0)) state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // pending rounds and round snapshot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q      <= '0;
            rem_q       <= '0;
            snap_q      <= '0;
            word_snap_q <= '0;
        end else begin
            pend_q <= pend_q + PEND_W'(pend_inc) - PEND_W'(round_take);
            if (round_take) begin
                rem_q       <= mask;
                snap_q      <= mask;
                word_snap_q <= word;
            end else if (fire) begin
                rem_q <= rem_after;
            end
        end
    end

    // outputs
    always_comb begin
        pkt_valid = (state_q == ST_SEND);
        pkt_addr  = addr_tbl[cur_slot];
        pkt_data  = word_snap_q;
        pkt_slot  = cur_slot;
    end

    // R8: a stalled packet stays put
    a_r8_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && !pkt_ready) |=>
            (pkt_valid && $stable(pkt_slot) && $stable(pkt_data) && $stable(pkt_addr)));

    // R7: within a round slots strictly ascend, and a round is followed by a gap
    a_r7_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_valid && pkt_ready) |=> (!pkt_valid || (pkt_slot > $past(pkt_slot))));

    // R7: only slots enabled at round start are sent
    a_r7_enabled_slot: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_valid |-> snap_q[pkt_slot]);

    // R7: sending always has a slot left
    a_r7_send_has_slot: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SEND) |-> (rem_q != '0));

endmodule

// File: rtl/evt_zero_notifier.sv
module evt_zero_notifier
    import ezn_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int N_SLOT = 4,
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int CFG_W  = 32,
    parameter int PEND_W = 3,
    parameter int SLOT_W = (N_SLOT > 1) ? $clog2(N_SLOT) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_valid,
    input  logic [1:0]        cfg_op,
    input  logic [SLOT_W-1:0] cfg_slot,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              st_valid,
    input  logic [CNT_W-1:0]  st_value,
    input  logic              ack_valid,
    input  logic [CNT_W-1:0]  ack_size,
    output logic              pkt_valid,
    input  logic              pkt_ready,
    output logic [ADDR_W-1:0] pkt_addr,
    output logic [WORD_W-1:0] pkt_data,
    output logic [SLOT_W-1:0] pkt_slot,
    output logic [CNT_W-1:0]  count_value
);

    logic                          load_en;
    logic [CNT_W-1:0]              load_val;
    logic                          zero_hit;
    logic [N_SLOT-1:0][ADDR_W-1:0] addr_tbl;
    logic [WORD_W-1:0]             word_q;
    logic [N_SLOT-1:0]             mask_q;

    always_comb begin
        load_en  = cfg_valid && (cfg_op == CFG_LOAD);
        load_val = CNT_W'(cfg_data);
    end

    ezn_accum #(
        .CNT_W (CNT_W)
    ) u_accum (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_en   (load_en),
        .load_val  (load_val),
        .st_valid  (st_valid),
        .st_value  (st_value),
        .ack_valid (ack_valid),
        .ack_size  (ack_size),
        .count_q   (count_value),
        .zero_hit  (zero_hit)
    );

    ezn_cfg_regs #(
        .N_SLOT (N_SLOT),
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .CFG_W  (CFG_W),
        .SLOT_W (SLOT_W)
    ) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_op    (cfg_op),
        .cfg_slot  (cfg_slot),
        .cfg_data  (cfg_data),
        .addr_tbl  (addr_tbl),
        .word_q    (word_q),
        .mask_q    (mask_q)
    );

    ezn_notify_seq #(
        .N_SLOT (N_SLOT),
        .ADDR_W (ADDR_W),
        .WORD_W (WORD_W),
        .PEND_W (PEND_W),
        .SLOT_W (SLOT_W)
    ) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .zero_hit  (zero_hit),
        .mask      (mask_q),
        .word      (word_q),
        .addr_tbl  (addr_tbl),
        .pkt_ready (pkt_ready),
        .pkt_valid (pkt_valid),
        .pkt_addr  (pkt_addr),
        .pkt_data  (pkt_data),
        .pkt_slot  (pkt_slot)
    );

    // R11: idle sequencer raises valid one cycle after the zero shows
    a_r11_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_hit && !pkt_valid) |=> !pkt_valid);

endmodule

// File: tb/tb_evt_zero_notifier.sv
`timescale 1ns/1ps
module tb_evt_zero_notifier;

    localparam int CNT_W = 32;
    localparam int ADDR_W = 32;
    localparam int WORD_W = 32;
    localparam int CFG_W = 32;
    localparam int SLOT_W = 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_valid = 1'b0;
    logic [1:0]        cfg_op = '0;
    logic [SLOT_W-1:0] cfg_slot = '0;
    logic [CFG_W-1:0]  cfg_data = '0;
    logic              st_valid = 1'b0;
    logic [CNT_W-1:0]  st_value = '0;
    logic              ack_valid = 1'b0;
    logic [CNT_W-1:0]  ack_size = '0;
    logic              pkt_valid;
    logic              pkt_ready = 1'b1;
    logic [ADDR_W-1:0] pkt_addr;
    logic [WORD_W-1:0] pkt_data;
    logic [SLOT_W-1:0] pkt_slot;
    logic [CNT_W-1:0]  count_value;

    evt_zero_notifier dut (
        .clk (clk), .rst_n (rst_n),
        .cfg_valid (cfg_valid), .cfg_op (cfg_op), .cfg_slot (cfg_slot), .cfg_data (cfg_data),
        .st_valid (st_valid), .st_value (st_value),
        .ack_valid (ack_valid), .ack_size (ack_size),
        .pkt_valid (pkt_valid), .pkt_ready (pkt_ready),
        .pkt_addr (pkt_addr), .pkt_data (pkt_data), .pkt_slot (pkt_slot),
        .count_value (count_value)
    );

    always #2.5 clk = ~clk;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    // packet log, sampled just before each rising edge
    logic [31:0] log_addr [64];
    logic [31:0] log_data [64];
    int          log_slot [64];
    int          log_n = 0;

    always begin
        @(negedge clk);
        #2;
        if (pkt_valid && pkt_ready && log_n < 64) begin
            log_addr[log_n] = pkt_addr;
            log_data[log_n] = pkt_data;
            log_slot[log_n] = int'(pkt_slot);
            log_n = log_n + 1;
        end
    end

    // ready patterns: 0 always, 1 alternate, 2 one in three, 3 held low
    int rdy_mode = 0;
    int rdy_cnt = 0;
    always @(negedge clk) begin
        rdy_cnt = rdy_cnt + 1;
        case (rdy_mode)
            0: pkt_ready = 1'b1;
            1: pkt_ready = rdy_cnt[0];
            2: pkt_ready = ((rdy_cnt % 3) == 0);
            default: pkt_ready = 1'b0;
        endcase
    end

    function automatic logic [31:0] slot_addr(int s);
        return 32'h4000_0100 + 32'(s) * 32'h18;
    endfunction

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(bit c_en, logic [1:0] op, int slot, logic [31:0] data,
                         bit s_en, logic [31:0] s_v, bit a_en, logic [31:0] a_v);
        @(negedge clk);
        cfg_valid = c_en; cfg_op = op; cfg_slot = SLOT_W'(slot); cfg_data = data;
        st_valid = s_en; st_value = s_v; ack_valid = a_en; ack_size = a_v;
        @(negedge clk);
        cfg_valid = 1'b0; st_valid = 1'b0; ack_valid = 1'b0;
    endtask

    task automatic cfg_wr(logic [1:0] op, int slot, logic [31:0] data);
        drive(1'b1, op, slot, data, 1'b0, '0, 1'b0, '0);
    endtask

    task automatic store(logic [31:0] v);
        drive(1'b0, 2'd0, 0, '0, 1'b1, v, 1'b0, '0);
    endtask

    task automatic ack(logic [31:0] v);
        drive(1'b0, 2'd0, 0, '0, 1'b0, '0, 1'b1, v);
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            fails = fails + 1;
            checks = checks + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] c;
        int e;
        int pc;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        chk(count_value == 0, "R1 count after reset", count_value, 0);
        chk(pkt_valid == 0, "R1 valid after reset", pkt_valid, 0);

        for (int s = 0; s < 4; s++) cfg_wr(2'd0, s, slot_addr(s));
        cfg_wr(2'd1, 0, 32'hBEEF_0000);

        // R1 mask is zero after reset: crossing sends nothing
        log_n = 0;
        cfg_wr(2'd3, 0, 32'd1);
        store(32'hFFFF_FFFF);
        idle(10);
        chk(log_n == 0, "R1 empty mask after reset", log_n, 0);

        // R2 / R3 arithmetic sweep
        for (int k = 0; k < 8; k++) begin
            a = 32'h1357_9BDF * 32'(k + 1);
            b = 32'h0F0F_1234 ^ (32'(k) << 20);
            c = 32'h0000_0777 * 32'(k + 3);
            cfg_wr(2'd3, 0, a);
            chk(count_value == a, "R4 load value", count_value, a);
            store(b);
            chk(count_value == a + b, "R2 store adds", count_value, a + b);
            ack(c);
            chk(count_value == a + b + c, "R3 ack adds", count_value, a + b + c);
            drive(1'b0, 2'd0, 0, '0, 1'b1, b, 1'b1, c);
            chk(count_value == a + 2 * b + 2 * c, "R3 store and ack sum", count_value, a + 2 * b + 2 * c);
        end
        // R2 wrap
        cfg_wr(2'd3, 0, 32'h7FFF_FFFF);
        store(32'd1);
        chk(count_value == 32'h8000_0000, "R2 wrap", count_value, 32'h8000_0000);
        idle(2);
        chk(count_value == 32'h8000_0000, "R2 hold", count_value, 32'h8000_0000);
        // R4 load beats add
        drive(1'b1, 2'd3, 0, 32'd100, 1'b1, 32'd5, 1'b1, 32'd7);
        chk(count_value == 32'd100, "R4 load priority", count_value, 100);

        // R6 / R7 / R8 mask sweep
        for (int m = 0; m < 16; m++) begin
            rdy_mode = m % 3;
            cfg_wr(2'd2, 0, 32'(m));
            cfg_wr(2'd1, 0, 32'hA5A5_0000 | 32'(m));
            cfg_wr(2'd3, 0, 32'd7);
            log_n = 0;
            store(32'hFFFF_FFF9);
            if (m == 5) begin
                chk(count_value == 0 && pkt_valid == 0, "R11 not yet valid", pkt_valid, 0);
                idle(1);
                chk(pkt_valid == 1, "R11 valid next cycle", pkt_valid, 1);
            end
            idle(16);
            pc = 0;
            for (int s = 0; s < 4; s++) if (m[s]) pc = pc + 1;
            chk(log_n == pc, "R7 packet count", log_n, pc);
            e = 0;
            for (int s = 0; s < 4; s++) begin
                if (m[s] && e < log_n) begin
                    chk(log_slot[e] == s, "R7 slot order", log_slot[e], s);
                    chk(log_addr[e] == slot_addr(s), "R6 address", log_addr[e], slot_addr(s));
                    chk(log_data[e] == (32'hA5A5_0000 | 32'(m)), "R6 word", log_data[e], 32'hA5A5_0000 | 32'(m));
                    e = e + 1;
                end
            end
        end
        rdy_mode = 0;

        // R4 / R5 no-trigger cases
        cfg_wr(2'd2, 0, 32'hF);
        log_n = 0;
        cfg_wr(2'd3, 0, 32'd0);
        store(32'd0);
        drive(1'b0, 2'd0, 0, '0, 1'b1, 32'd3, 1'b1, 32'hFFFF_FFFD);
        idle(10);
        chk(log_n == 0, "R5 zero stays zero", log_n, 0);
        chk(count_value == 0, "R5 count zero", count_value, 0);

        // R10 credit pool
        cfg_wr(2'd2, 0, 32'h3);
        log_n = 0;
        for (int i = 0; i < 3; i++) store(32'hFFFF_FFEC);
        idle(6);
        chk(count_value == 32'hFFFF_FFC4, "R10 credits taken", count_value, 32'hFFFF_FFC4);
        chk(log_n == 0, "R10 no packet on debit", log_n, 0);
        for (int i = 0; i < 3; i++) ack(32'd20);
        idle(10);
        chk(count_value == 0, "R10 credits back", count_value, 0);
        chk(log_n == 2, "R10 one round", log_n, 2);

        // R9 queued rounds under stall
        cfg_wr(2'd2, 0, 32'hF);
        cfg_wr(2'd3, 0, 32'd1);
        rdy_mode = 3;
        idle(2);
        log_n = 0;
        store(32'hFFFF_FFFF);
        idle(3);
        store(32'd9);
        ack(32'hFFFF_FFF7);
        store(32'd4);
        store(32'hFFFF_FFFC);
        idle(2);
        chk(count_value == 0, "R9 adds applied in round", count_value, 0);
        chk(pkt_valid == 1, "R8 valid held on stall", pkt_valid, 1);
        chk(log_n == 0, "R8 nothing taken on stall", log_n, 0);
        rdy_mode = 0;
        idle(30);
        chk(log_n == 12, "R9 three rounds", log_n, 12);
        for (int i = 0; i < 12 && i < log_n; i++)
            chk(log_slot[i] == i % 4, "R9 round order", log_slot[i], i % 4);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule